// File: doc/BRIEF.md
# Banked Interrupt Controller with Latched NMI

This block gathers 81 interrupt sources, organised as three 32-bit banks, and turns them into two request lines toward a processor: a normal request line and a fast request line. Source n sits in bank n/32 at bit n%32. Software programs each source through a plain 32-bit register port with byte offsets. Each source has three settings: an enable bit, an independent mask bit and a route bit that picks which of the two lines it feeds. Software reads back the gated requests as two separate pending views, one per line. It can also read a vector word that points at the handler of the lowest-numbered pending source on the normal line.

Source 0 is not a plain level input. It is an external non-maskable-style pin. A sticky latch catches that pin on a trigger condition that software selects, and the latch holds until software clears it by writing a one. Sources 1 to 80 are level inputs with no storage. A protection switch can be set so that only privileged bus writes reach the registers.

Top module: `irq_bank_ctrl`

## Requirements
- R1: After reset, every enable and route bit reads 0, every implemented mask bit reads 1, the protection, trigger and base registers read 0, and both request lines are low.
- R2: A source appears in a pending view only while its enable bit is 1 and its mask bit is 0. Setting mask or clearing enable removes it.
- R3: A route bit of 0 places the source in the normal pending view (offsets 0x10, 0x14, 0x18). A route bit of 1 places it in the fast pending view (offsets 0x20, 0x24, 0x28). No source is ever in both views.
- R4: For sources 1 to 80 the pending bit follows the raw input level with no storage. It drops as soon as the input falls.
- R5: The source 0 latch stays set after its trigger goes away. Writing 1 to bit 0 of pending bank 0 (offset 0x10 or 0x20) clears it, and writing 0 there has no effect. If a clear write and a trigger fall in the same cycle, the clear wins, and the latch sets again on the next cycle if the trigger is still present.
- R6: The trigger field, bits [1:0] at offset 0x0C, selects how the latch sets: 0 = pin low, 1 = pin high, 2 = falling edge, 3 = rising edge.
- R7: The vector word at offset 0x00 reads base + 4 × (lowest-numbered source in the normal pending view). When that view is empty it reads base alone. The base register at offset 0x04 stores bits [31:2], and bits [1:0] read as 0.
- R8: Bits 17 to 31 of bank 2, which have no source behind them, ignore writes and read as 0 in the enable, mask, route and pending registers.
- R9: When bit 0 of the protection register (offset 0x08) is 1, writes with the privilege input low change no register. Privileged writes are still accepted.
- R10: The normal and fast request lines are registered. Each equals, one clock later, the OR of its pending view.
- R11: The route banks sit at 0x30, 0x34 and 0x38, the enable banks at 0x40 to 0x48 and the mask banks at 0x50 to 0x58. Accesses with bits [1:0] of the address not equal to 0 are not decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 80 | Level inputs for sources 1 to 80 (bit n is source n) |
| nmi_i | input | 1 | External pin for source 0 |
| bus_addr_i | input | 8 | Byte offset of the register access |
| bus_wen_i | input | 1 | Write strobe, one cycle per write |
| bus_priv_i | input | 1 | Marks the write as privileged |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| irq_o | output | 1 | Normal request line |
| fiq_o | output | 1 | Fast request line |

## Verification
Two events can land on the latch for source 0 in the same cycle: a software clear (a write of one to pending bank 0) and a trigger from the pin. The bench provokes this collision by holding the pin in its active level while it issues the clear. It then checks that the pending view shows 0 right after the write edge and shows 1 again one edge later. A second overlap is an unprivileged write arriving while protection is on; it is judged by reading the targeted bank back unchanged. Random rounds then vary enable, mask, route and input levels together, and check both views, the vector word and the request lines against a bench model.

// File: rtl/intc_pkg.sv
// Package: shared types and helpers for the banked interrupt controller.
// Assumes 32-bit register words and at most four banks per register group.
package intc_pkg;

    localparam int WORD_W = 32;

    // Register groups, decoded from address bits [7:4]
    typedef enum logic [3:0] {
        GRP_CTRL = 4'h0,
        GRP_NPND = 4'h1,
        GRP_FPND = 4'h2,
        GRP_ROUT = 4'h3,
        GRP_ENAB = 4'h4,
        GRP_MASK = 4'h5
    } grp_e;

    // Words inside the control group, decoded from address bits [3:2]
    localparam logic [1:0] CW_VECTOR = 2'd0;
    localparam logic [1:0] CW_BASE   = 2'd1;
    localparam logic [1:0] CW_GUARD  = 2'd2;
    localparam logic [1:0] CW_TRIG   = 2'd3;

    // Trigger modes for the source 0 latch
    typedef enum logic [1:0] {
        TRIG_LOW  = 2'd0,
        TRIG_HIGH = 2'd1,
        TRIG_FALL = 2'd2,
        TRIG_RISE = 2'd3
    } trig_e;

    // Bits of bank b that have a real source behind them
    function automatic logic [WORD_W-1:0] bank_valid(input int nsrc, input int b);
        logic [WORD_W-1:0] v;
        for (int i = 0; i < WORD_W; i++) begin
            v[i] = ((b * WORD_W + i) < nsrc);
        end
        return v;
    endfunction

endpackage

// File: rtl/intc_cfg_regs.sv
// Module: configuration storage for the banked controller.
// Holds per-source enable, mask and route banks, plus the base, protection
// and trigger registers. Applies the protection rule to every write.
// Assumes word-aligned writes and NBANK <= 4. Bits without a source behind
// them are held at their reset value by a constant mask.
module intc_cfg_regs
    import intc_pkg::*;
#(
    parameter int NSRC  = 81,
    parameter int NBANK = (NSRC + WORD_W - 1) / WORD_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [7:0]                    addr_i,
    input  logic                          wen_i,
    input  logic                          priv_i,
    input  logic [WORD_W-1:0]             wdata_i,
    output logic [NBANK-1:0][WORD_W-1:0]  en_o,
    output logic [NBANK-1:0][WORD_W-1:0]  mask_o,
    output logic [NBANK-1:0][WORD_W-1:0]  rout_o,
    output logic [WORD_W-1:0]             base_o,
    output logic                          guard_o,
    output trig_e                         trig_o,
    output logic                          clr_o
);

    grp_e       grp;
    logic [1:0] widx;
    logic       wr_ok;

    // Split the address and qualify the write by alignment and protection
    always_comb begin
        grp   = grp_e'(addr_i[7:4]);
        widx  = addr_i[3:2];
        wr_ok = wen_i && (addr_i[1:0] == 2'b00) && (!guard_o || priv_i);
    end

    // A one written to bit 0 of either pending bank 0 clears the latch
    assign clr_o = wr_ok && ((grp == GRP_NPND) || (grp == GRP_FPND))
                   && (widx == 2'd0) && wdata_i[0];

    // Control group storage: base, protection and trigger mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_o  <= '0;
            guard_o <= 1'b0;
            trig_o  <= TRIG_LOW;
        end else if (wr_ok && (grp == GRP_CTRL)) begin
            case (widx)
                CW_BASE:  base_o  <= {wdata_i[WORD_W-1:2], 2'b00};
                CW_GUARD: guard_o <= wdata_i[0];
                CW_TRIG:  trig_o  <= trig_e'(wdata_i[1:0]);
                default:  ;
            endcase
        end
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam logic [WORD_W-1:0] VALID = bank_valid(NSRC, b);
        logic hit;
        assign hit = wr_ok && (widx == 2'(b));

        // Per-bank storage of enable, mask and route bits
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_o[b]   <= '0;
                mask_o[b] <= VALID;
                rout_o[b] <= '0;
            end else if (hit) begin
                case (grp)
                    GRP_ENAB: en_o[b]   <= wdata_i & VALID;
                    GRP_MASK: mask_o[b] <= wdata_i & VALID;
                    GRP_ROUT: rout_o[b] <= wdata_i & VALID;
                    default:  ;
                endcase
            end
        end
    end

endmodule

// File: rtl/intc_nmi_latch.sv
// Module: sticky capture for source 0.
// Sets on the chosen pin condition. A clear takes priority over a set in
// the same cycle. Edge modes compare the pin with its value at the
// previous edge. Assumes the pin is already in the clock domain.
module intc_nmi_latch
    import intc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  pin_i,
    input  trig_e trig_i,
    input  logic  clr_i,
    output logic  pend_o
);

    logic pin_q;
    logic fire;

    // Decode the trigger condition for this cycle
    always_comb begin
        case (trig_i)
            TRIG_LOW:  fire = !pin_i;
            TRIG_HIGH: fire = pin_i;
            TRIG_FALL: fire = pin_q && !pin_i;
            TRIG_RISE: fire = !pin_q && pin_i;
            default:   fire = 1'b0;
        endcase
    end

    // Remember the previous pin value and update the sticky bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q  <= 1'b0;
            pend_o <= 1'b0;
        end else begin
            pin_q  <= pin_i;
            pend_o <= clr_i ? 1'b0 : (pend_o || fire);
        end
    end

endmodule

// File: rtl/intc_lowest.sv
// Module: finds the lowest set bit of a request vector.
// Purely combinational. The scan runs from the top bit down so that the
// last hit, which is the lowest index, wins.
module intc_lowest #(
    parameter int W  = 81,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  req_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);

    // Priority scan, lowest index has precedence
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/irq_bank_ctrl.sv
// Module: top of the banked interrupt controller.
// Gates every source by enable and mask, splits the gated requests into a
// normal and a fast pending view using the route bits, registers the two
// request lines and serves register reads. Source 0 is the latched pin;
// sources 1 to NSRC-1 are level inputs. Reads are combinational.
module irq_bank_ctrl
    import intc_pkg::*;
#(
    parameter int NSRC  = 81,
    parameter int NBANK = (NSRC + WORD_W - 1) / WORD_W,
    parameter int IW    = $clog2(NSRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:1]   src_i,
    input  logic              nmi_i,
    input  logic [7:0]        bus_addr_i,
    input  logic              bus_wen_i,
    input  logic              bus_priv_i,
    input  logic [WORD_W-1:0] bus_wdata_i,
    output logic [WORD_W-1:0] bus_rdata_o,
    output logic              irq_o,
    output logic              fiq_o
);

    localparam int FLAT = NBANK * WORD_W;

    logic [NBANK-1:0][WORD_W-1:0] en_q, mask_q, rout_q;
    logic [NBANK-1:0][WORD_W-1:0] npnd_b, fpnd_b;
    logic [FLAT-1:0]              en_flat, mask_flat, rout_flat;
    logic [WORD_W-1:0]            base_q;
    logic                         guard_q;
    trig_e                        trig_q;
    logic                         nmi_clr;
    logic                         nmi_pend;
    logic [NSRC-1:0]              raw, gated, irq_view, fiq_view;
    logic                         vec_found;
    logic [IW-1:0]                vec_idx;

    intc_cfg_regs #(.NSRC(NSRC), .NBANK(NBANK)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (bus_addr_i),
        .wen_i   (bus_wen_i),
        .priv_i  (bus_priv_i),
        .wdata_i (bus_wdata_i),
        .en_o    (en_q),
        .mask_o  (mask_q),
        .rout_o  (rout_q),
        .base_o  (base_q),
        .guard_o (guard_q),
        .trig_o  (trig_q),
        .clr_o   (nmi_clr)
    );

    intc_nmi_latch u_nmi (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (nmi_i),
        .trig_i (trig_q),
        .clr_i  (nmi_clr),
        .pend_o (nmi_pend)
    );

    // Flatten the banks so that source n is bit n
    assign en_flat   = en_q;
    assign mask_flat = mask_q;
    assign rout_flat = rout_q;

    // Gate raw requests and split them by route bit
    always_comb begin
        raw      = {src_i, nmi_pend};
        gated    = raw & en_flat[NSRC-1:0] & ~mask_flat[NSRC-1:0];
        irq_view = gated & ~rout_flat[NSRC-1:0];
        fiq_view = gated & rout_flat[NSRC-1:0];
        npnd_b   = FLAT'(irq_view);
        fpnd_b   = FLAT'(fiq_view);
    end

    intc_lowest #(.W(NSRC), .IW(IW)) u_low (
        .req_i   (irq_view),
        .found_o (vec_found),
        .idx_o   (vec_idx)
    );

    // Register the two request lines toward the processor
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
            fiq_o <= 1'b0;
        end else begin
            irq_o <= |irq_view;
            fiq_o <= |fiq_view;
        end
    end

    // Read multiplexer over all register groups
    always_comb begin
        logic [1:0] widx;
        logic       bok;
        widx        = bus_addr_i[3:2];
        bok         = (int'(widx) < NBANK);
        bus_rdata_o = '0;
        if (bus_addr_i[1:0] == 2'b00) begin
            case (grp_e'(bus_addr_i[7:4]))
                GRP_CTRL: begin
                    case (widx)
                        CW_VECTOR: bus_rdata_o = vec_found
                                   ? base_q + (WORD_W'(vec_idx) << 2) : base_q;
                        CW_BASE:   bus_rdata_o = base_q;
                        CW_GUARD:  bus_rdata_o = {{(WORD_W-1){1'b0}}, guard_q};
                        default:   bus_rdata_o = {{(WORD_W-2){1'b0}}, trig_q};
                    endcase
                end
                GRP_NPND: if (bok) bus_rdata_o = npnd_b[widx];
                GRP_FPND: if (bok) bus_rdata_o = fpnd_b[widx];
                GRP_ROUT: if (bok) bus_rdata_o = rout_q[widx];
                GRP_ENAB: if (bok) bus_rdata_o = en_q[widx];
                GRP_MASK: if (bok) bus_rdata_o = mask_q[widx];
                default:  bus_rdata_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/intc_checker.sv
// Module: assertion checker for irq_bank_ctrl, bound to every instance.
// Observes the pending views, the request lines, the source 0 latch and
// the enable storage.
module intc_checker #(
    parameter int NSRC  = 81,
    parameter int NBANK = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NSRC-1:0]       irq_view,
    input logic [NSRC-1:0]       fiq_view,
    input logic                  irq_o,
    input logic                  fiq_o,
    input logic                  nmi_pend,
    input logic                  nmi_clr,
    input logic [NBANK*32-1:0]   en_flat,
    input logic                  guard_q,
    input logic                  bus_wen_i,
    input logic                  bus_priv_i
);

    // R3: a source is never routed to both views
    assert_route_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_view & fiq_view) == '0);

    // R10: each request line follows the OR of its view one clock later
    assert_irq_line_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (irq_o == $past(|irq_view)));

    assert_fiq_line_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (fiq_o == $past(|fiq_view)));

    // R5: the latch holds unless cleared, and a clear always empties it
    assert_nmi_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_pend && !nmi_clr) |=> nmi_pend);

    assert_nmi_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_clr |=> !nmi_pend);

    // R9: a guarded unprivileged write leaves the enable banks untouched
    assert_guard_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (guard_q && bus_wen_i && !bus_priv_i) |=> $stable(en_flat));

endmodule

bind irq_bank_ctrl intc_checker #(.NSRC(NSRC), .NBANK(NBANK)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_view   (irq_view),
    .fiq_view   (fiq_view),
    .irq_o      (irq_o),
    .fiq_o      (fiq_o),
    .nmi_pend   (nmi_pend),
    .nmi_clr    (nmi_clr),
    .en_flat    (en_flat),
    .guard_q    (guard_q),
    .bus_wen_i  (bus_wen_i),
    .bus_priv_i (bus_priv_i)
);

// File: tb/irq_bank_ctrl_tb.sv
module irq_bank_ctrl_tb;

    localparam int NSRC = 81;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [80:1] src = '0;
    logic        nmi = 1'b1;
    logic [7:0]  addr = '0;
    logic        wen = 1'b0;
    logic        priv = 1'b1;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, fiq;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_en[3], m_mask[3], m_rout[3];
    logic [31:0] m_base = '0;
    logic        m_latch = 1'b0;
    logic [31:0] val[3];

    irq_bank_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .nmi_i(nmi),
        .bus_addr_i(addr), .bus_wen_i(wen), .bus_priv_i(priv),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq), .fiq_o(fiq)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic p = 1'b1);
        @(negedge clk);
        addr = a; wdata = d; priv = p; wen = 1'b1;
        @(posedge clk);
        #1 wen = 1'b0; priv = 1'b1;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    // Configure an enable (0x40), mask (0x50) or route (0x30) bank and track it
    task automatic cfg(input logic [7:0] grp, input int b, input logic [31:0] d);
        wr(grp + 8'(4 * b), d);
        case (grp)
            8'h40: m_en[b] = d & val[b];
            8'h50: m_mask[b] = d & val[b];
            default: m_rout[b] = d & val[b];
        endcase
    endtask

    function automatic logic [31:0] exp_view(input int b, input bit fast);
        logic [31:0] v;
        for (int i = 0; i < 32; i++) begin
            int n = b * 32 + i;
            logic a;
            a = (n == 0) ? m_latch : ((n < NSRC) ? src[n] : 1'b0);
            v[i] = a && m_en[b][i] && !m_mask[b][i] && (m_rout[b][i] == fast);
        end
        return v;
    endfunction

    function automatic logic [31:0] exp_vec();
        for (int n = NSRC - 1; n >= 0; n--) begin end
        for (int n = 0; n < NSRC; n++) begin
            if (exp_view(n / 32, 1'b0)[n % 32]) return m_base + 32'(4 * n);
        end
        return m_base;
    endfunction

    function automatic bit any_view(input bit fast);
        return |{exp_view(0, fast), exp_view(1, fast), exp_view(2, fast)};
    endfunction

    task automatic check_views(input string req);
        logic [31:0] d;
        for (int b = 0; b < 3; b++) begin
            rd(8'h10 + 8'(4 * b), d); chk(req, d, exp_view(b, 1'b0));
            rd(8'h20 + 8'(4 * b), d); chk(req, d, exp_view(b, 1'b1));
        end
        rd(8'h00, d); chk(req, d, exp_vec());
    endtask

    task automatic check_lines(input string req);
        @(posedge clk);
        @(negedge clk);
        chk(req, {31'b0, irq}, {31'b0, any_view(1'b0)});
        chk(req, {31'b0, fiq}, {31'b0, any_view(1'b1)});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd1234));
        for (int b = 0; b < 3; b++) begin
            for (int i = 0; i < 32; i++) val[b][i] = (b * 32 + i) < NSRC;
            m_en[b] = '0; m_mask[b] = val[b]; m_rout[b] = '0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state (R8 for the tail of mask bank 2)
        for (int b = 0; b < 3; b++) begin
            rd(8'h40 + 8'(4 * b), d); chk("R1 enable", d, 32'h0);
            rd(8'h30 + 8'(4 * b), d); chk("R1 route", d, 32'h0);
            rd(8'h50 + 8'(4 * b), d); chk("R1 R8 mask", d, val[b]);
        end
        rd(8'h08, d); chk("R1 guard", d, 32'h0);
        rd(8'h0C, d); chk("R1 trigger", d, 32'h0);
        rd(8'h00, d); chk("R1 vector", d, 32'h0);
        chk("R1 lines", {30'b0, irq, fiq}, 32'h0);

        // R8 tail bits ignore writes; R11 misaligned access not decoded
        wr(8'h48, 32'hFFFF_FFFF); rd(8'h48, d); chk("R8 enable tail", d, 32'h0001_FFFF);
        rd(8'h49, d); chk("R11 misaligned read", d, 32'h0);
        wr(8'h4A, 32'h0); rd(8'h48, d); chk("R11 misaligned write", d, 32'h0001_FFFF);
        wr(8'h48, 32'h0);

        // R2 gating by enable and mask; R10 line timing
        src[5] = 1'b1;
        cfg(8'h40, 0, 32'h20);
        rd(8'h10, d); chk("R2 masked", d, 32'h0);
        cfg(8'h50, 0, m_mask[0] & ~32'h20);
        rd(8'h10, d); chk("R2 unmasked", d, 32'h20);
        check_lines("R10 irq rises");
        cfg(8'h40, 0, 32'h0);
        rd(8'h10, d); chk("R2 disabled", d, 32'h0);
        check_lines("R10 irq falls");

        // R3 route to the fast view
        cfg(8'h40, 0, 32'h20);
        cfg(8'h30, 0, 32'h20);
        check_views("R3 fast route");
        check_lines("R3 R10 fast line");
        cfg(8'h30, 0, 32'h0);
        cfg(8'h40, 0, 32'h0);
        src[5] = 1'b0;

        // R7 vector with base; R4 level following
        wr(8'h04, 32'h0000_1003); m_base = 32'h1000;
        rd(8'h04, d); chk("R7 base low bits", d, 32'h1000);
        cfg(8'h40, 1, 32'h100); cfg(8'h50, 1, 32'h0);
        cfg(8'h40, 2, 32'h40);  cfg(8'h50, 2, 32'h0);
        src[40] = 1'b1; src[70] = 1'b1;
        rd(8'h00, d); chk("R7 vector src40", d, 32'h1000 + 4 * 40);
        src[40] = 1'b0;
        rd(8'h00, d); chk("R7 vector src70", d, 32'h1000 + 4 * 70);
        rd(8'h14, d); chk("R4 level drop", d, 32'h0);
        src[70] = 1'b0;
        rd(8'h00, d); chk("R7 vector empty", d, 32'h1000);

        // R5 latch, low-level mode (R6 code 0)
        cfg(8'h40, 0, 32'h1); cfg(8'h50, 0, m_mask[0] & ~32'h1);
        wr(8'h10, 32'h1);
        rd(8'h10, d); chk("R5 start clear", d, 32'h0);
        @(negedge clk) nmi = 1'b0;
        @(negedge clk) nmi = 1'b1;
        m_latch = 1'b1;
        rd(8'h10, d); chk("R5 R6 low sets", d, 32'h1);
        rd(8'h00, d); chk("R7 vector src0", d, 32'h1000);
        wr(8'h10, 32'h0);
        rd(8'h10, d); chk("R5 zero write", d, 32'h1);
        wr(8'h20, 32'h1); m_latch = 1'b0;
        rd(8'h10, d); chk("R5 clear via fast bank", d, 32'h0);
        // R5 collision: clear while trigger active
        @(negedge clk) nmi = 1'b0;
        wr(8'h10, 32'h1);
        #2 chk("R5 clear wins", rdata_at(8'h10), 32'h0);
        @(posedge clk); #2;
        chk("R5 resets next cycle", rdata_at(8'h10), 32'h1);
        // R6 rising edge
        wr(8'h0C, 32'h3);
        wr(8'h10, 32'h1);
        repeat (2) @(posedge clk);
        rd(8'h10, d); chk("R6 rise idle", d, 32'h0);
        @(negedge clk) nmi = 1'b1;
        rd(8'h10, d); chk("R6 rise sets", d, 32'h1);
        // R6 falling edge
        wr(8'h0C, 32'h2);
        wr(8'h10, 32'h1);
        repeat (2) @(posedge clk);
        rd(8'h10, d); chk("R6 fall idle", d, 32'h0);
        @(negedge clk) nmi = 1'b0;
        rd(8'h10, d); chk("R6 fall sets", d, 32'h1);
        // R6 high level
        wr(8'h0C, 32'h1);
        wr(8'h10, 32'h1);
        repeat (2) @(posedge clk);
        rd(8'h10, d); chk("R6 high idle", d, 32'h0);
        @(negedge clk) nmi = 1'b1;
        rd(8'h10, d); chk("R6 high sets", d, 32'h1);
        wr(8'h0C, 32'h0);
        wr(8'h10, 32'h1);
        rd(8'h10, d); chk("R5 final clear", d, 32'h0);
        cfg(8'h40, 0, 32'h0);

        // R9 protection
        wr(8'h08, 32'h1);
        wr(8'h44, 32'h00FF_0000, 1'b0);
        rd(8'h44, d); chk("R9 unprivileged blocked", d, m_en[1]);
        cfg(8'h40, 1, 32'h00FF_0000);
        rd(8'h44, d); chk("R9 privileged accepted", d, 32'h00FF_0000);
        wr(8'h08, 32'h0);

        // Random rounds: R2 R3 R4 R7 R10
        for (int it = 0; it < 250; it++) begin
            int b = int'($urandom_range(0, 2));
            int g = int'($urandom_range(0, 2));
            logic [31:0] dd = $urandom;
            if (g == 0) begin
                if (b == 0) dd[0] = 1'b0;
                cfg(8'h40, b, dd);
            end else if (g == 1) begin
                cfg(8'h50, b, dd);
            end else begin
                cfg(8'h30, b, dd);
            end
            @(negedge clk);
            src = {$urandom, $urandom, $urandom} >> 16;
            if (it % 25 == 0) check_views("R2 R3 R4 R7 random views");
            else begin
                rd(8'h00, d); chk("R7 random vector", d, exp_vec());
            end
            check_lines("R10 random lines");
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Combinational read used mid-cycle for the collision check
    function automatic logic [31:0] rdata_at(input logic [7:0] a);
        addr = a;
        return rdata;
    endfunction

endmodule